// File: doc/BRIEF.md
# Cache Class-of-Service Mask Unit

This unit keeps, for a shared cache hierarchy, a table of way-allocation masks per class of service and resolves which masks apply to each incoming fill request. Software-style register accesses write and read the masks through an address-decoded port. A small per-thread association register holds the class index that the thread currently runs under, and is rewritten whenever a thread's context changes.

A request names a thread. The unit looks up that thread's class index and uses that one index in three separate tables at once: the second-level cache mask, the third-level data (or unified) mask, and the third-level code mask. The tables have their own depths. An index past a table's depth gives an unrestricted all-ones mask from that table only. When code/data prioritization is off, the third-level code output repeats the unified mask. Any written mask whose set bits do not form one unbroken run is refused.

Top module: `cos_mask_unit`

## Requirements
- R1: After reset every entry of every table is all ones, every thread's class index is 0, and a request returns all-ones masks on all three mask outputs.
- R2: A write of a contiguous mask to address 0xD10+n, with n below L2_COS, stores it as second-level entry n. A read of that address returns it in reg_rdata_o one cycle later, with reg_err_o low.
- R3: A write whose low MASK_W bits are zero or are not one contiguous run of ones is refused. The entry keeps its old value and reg_err_o is high for the one cycle after the write.
- R4: A read of an unimplemented address returns zero and raises reg_err_o for one cycle. Unimplemented addresses are a second-level index at or above L2_COS, a third-level index at or above L3_COS, the code range 0xCD0+n while l3_cdp_i is 0, and any address outside 0xC90..0xD4F.
- R5: Write data bits at and above MASK_W are ignored, and the same bits read back as zero.
- R6: A request on req_valid_i produces rsp_valid_o and the three masks one cycle later. The masks are selected by the class index that assoc_we_i/assoc_cos_i last stored for req_tid_i.
- R7: When the class index is at or above a table's depth (L2_COS for second level, L3_COS for third level), that table yields all ones, while the other tables still apply their own entry for that index.
- R8: The third-level unified/data masks sit at 0xC90+n. With l3_cdp_i=0, both l3_code_mask_o and l3_data_mask_o carry that entry. With l3_cdp_i=1, l3_code_mask_o comes from 0xCD0+n instead.
- R9: cap_o reports features. Bit 2 is 1 (second-level allocation present). Bits 1:0 are 01 when l3_cdp_i=0 (allocation only) and 10 when l3_cdp_i=1 (code/data prioritization).
- R10: A request uses the association value and the mask contents from before any association write or mask write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l3_cdp_i | input | 1 | Third-level code/data prioritization enable |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | 12 | Register address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data, one cycle after read |
| reg_err_o | output | 1 | Refused write or unimplemented read, one-cycle pulse |
| assoc_we_i | input | 1 | Association register write strobe |
| assoc_tid_i | input | TID_W | Thread whose association is written |
| assoc_cos_i | input | 6 | Class index to associate |
| req_valid_i | input | 1 | Fill request valid |
| req_tid_i | input | TID_W | Requesting thread |
| rsp_valid_o | output | 1 | Resolved masks valid |
| l2_mask_o | output | MASK_W | Second-level allowed-way mask |
| l3_code_mask_o | output | MASK_W | Third-level code allowed-way mask |
| l3_data_mask_o | output | MASK_W | Third-level data/unified allowed-way mask |
| cap_o | output | 3 | Capability status word |

## Verification
A fill request can arrive in the same cycle as an update that would change its answer. One case is an association write for the requesting thread; the other is a mask write to the entry that the request selects. The bench drives each update together with a request in the same cycle. It expects the pre-update mask in that response and the new mask on a request in the following cycle.

// File: rtl/cmu_pkg.sv
package cmu_pkg;
  localparam int COS_W = 6;
  localparam int SLOTS = 1 << COS_W;
  localparam logic [11:0] L3D_BASE = 12'hC90;
  localparam logic [11:0] L3C_BASE = 12'hCD0;
  localparam logic [11:0] L2_BASE  = 12'hD10;

  typedef enum logic [1:0] {
    L3_NONE  = 2'b00,
    L3_ALLOC = 2'b01,
    L3_CDP   = 2'b10
  } l3_state_e;
endpackage

// File: rtl/cmu_contig_chk.sv
module cmu_contig_chk #(
  parameter int W = 8
) (
  input  logic [W-1:0] mask_i,
  output logic         ok_o
);
  logic [W-1:0] lsb, sum;
  assign lsb  = mask_i & (~mask_i + W'(1));
  assign sum  = mask_i + lsb;
  // one run: adding the lowest set bit clears the whole run
  assign ok_o = (mask_i != '0) && ((sum & mask_i) == '0);
endmodule

// File: rtl/cmu_mask_table.sv
module cmu_mask_table #(
  parameter int MASK_W = 8,
  parameter int DEPTH  = 4,
  parameter int IDX_IN = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_IN-1:0] widx_i,
  input  logic [MASK_W-1:0] wmask_i,
  input  logic [IDX_IN-1:0] ridx_i,
  output logic [MASK_W-1:0] rmask_o,
  output logic              rhit_o,
  input  logic [IDX_IN-1:0] lidx_i,
  output logic [MASK_W-1:0] lmask_o
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [MASK_W-1:0] mem [DEPTH];
  logic w_in, r_in, l_in;

  assign w_in = 32'(widx_i) < DEPTH;
  assign r_in = 32'(ridx_i) < DEPTH;
  assign l_in = 32'(lidx_i) < DEPTH;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (we_i && w_in) begin
      mem[widx_i[IDX_W-1:0]] <= wmask_i;
    end
  end

  assign rhit_o  = r_in;
  assign rmask_o = r_in ? mem[ridx_i[IDX_W-1:0]] : '0;
  assign lmask_o = l_in ? mem[lidx_i[IDX_W-1:0]] : '1;
endmodule

// File: rtl/cmu_assoc_regs.sv
module cmu_assoc_regs #(
  parameter int THREADS = 2,
  parameter int COS_W   = 6,
  localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [TID_W-1:0] wtid_i,
  input  logic [COS_W-1:0] wcos_i,
  input  logic [TID_W-1:0] rtid_i,
  output logic [COS_W-1:0] rcos_o
);
  logic [COS_W-1:0] cos_q [THREADS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < THREADS; i++) cos_q[i] <= '0;
    end else if (we_i && (32'(wtid_i) < THREADS)) begin
      cos_q[wtid_i] <= wcos_i;
    end
  end

  assign rcos_o = (32'(rtid_i) < THREADS) ? cos_q[rtid_i] : '0;
endmodule

// File: rtl/cos_mask_unit.sv
module cos_mask_unit
  import cmu_pkg::*;
#(
  parameter int MASK_W  = 8,
  parameter int DATA_W  = 32,
  parameter int L2_COS  = 4,
  parameter int L3_COS  = 8,
  parameter int THREADS = 2,
  localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              l3_cdp_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [11:0]       reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              reg_err_o,
  input  logic              assoc_we_i,
  input  logic [TID_W-1:0]  assoc_tid_i,
  input  logic [COS_W-1:0]  assoc_cos_i,
  input  logic              req_valid_i,
  input  logic [TID_W-1:0]  req_tid_i,
  output logic              rsp_valid_o,
  output logic [MASK_W-1:0] l2_mask_o,
  output logic [MASK_W-1:0] l3_code_mask_o,
  output logic [MASK_W-1:0] l3_data_mask_o,
  output logic [2:0]        cap_o
);
  logic [11:0] off_l2, off_l3d, off_l3c;
  logic        in_l2, in_l3d, in_l3c;
  logic [COS_W-1:0] idx_l2, idx_l3d, idx_l3c;

  assign off_l2  = reg_addr_i - L2_BASE;
  assign off_l3d = reg_addr_i - L3D_BASE;
  assign off_l3c = reg_addr_i - L3C_BASE;
  assign in_l2   = off_l2  < 12'(SLOTS);
  assign in_l3d  = off_l3d < 12'(SLOTS);
  assign in_l3c  = (off_l3c < 12'(SLOTS)) && l3_cdp_i;
  assign idx_l2  = off_l2[COS_W-1:0];
  assign idx_l3d = off_l3d[COS_W-1:0];
  assign idx_l3c = off_l3c[COS_W-1:0];

  logic [MASK_W-1:0] wmask;
  logic              wmask_ok;
  logic [DATA_W-MASK_W-1:0] unused_wdata_hi;
  assign wmask = reg_wdata_i[MASK_W-1:0];
  assign unused_wdata_hi = reg_wdata_i[DATA_W-1:MASK_W];

  cmu_contig_chk #(.W(MASK_W)) u_contig (.mask_i(wmask), .ok_o(wmask_ok));

  logic [COS_W-1:0] req_cos;

  cmu_assoc_regs #(.THREADS(THREADS), .COS_W(COS_W)) u_assoc (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(assoc_we_i), .wtid_i(assoc_tid_i), .wcos_i(assoc_cos_i),
    .rtid_i(req_tid_i), .rcos_o(req_cos)
  );

  logic [MASK_W-1:0] r_l2, r_l3d, r_l3c, k_l2, k_l3d, k_l3c;
  logic              h_l2, h_l3d, h_l3c;
  logic              hit_l2, hit_l3d, hit_l3c, hit_any;

  assign hit_l2  = in_l2  && h_l2;
  assign hit_l3d = in_l3d && h_l3d;
  assign hit_l3c = in_l3c && h_l3c;
  assign hit_any = hit_l2 || hit_l3d || hit_l3c;

  cmu_mask_table #(.MASK_W(MASK_W), .DEPTH(L2_COS), .IDX_IN(COS_W)) u_tbl_l2 (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(reg_we_i && in_l2 && wmask_ok), .widx_i(idx_l2), .wmask_i(wmask),
    .ridx_i(idx_l2), .rmask_o(r_l2), .rhit_o(h_l2),
    .lidx_i(req_cos), .lmask_o(k_l2)
  );

  cmu_mask_table #(.MASK_W(MASK_W), .DEPTH(L3_COS), .IDX_IN(COS_W)) u_tbl_l3d (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(reg_we_i && in_l3d && wmask_ok), .widx_i(idx_l3d), .wmask_i(wmask),
    .ridx_i(idx_l3d), .rmask_o(r_l3d), .rhit_o(h_l3d),
    .lidx_i(req_cos), .lmask_o(k_l3d)
  );

  cmu_mask_table #(.MASK_W(MASK_W), .DEPTH(L3_COS), .IDX_IN(COS_W)) u_tbl_l3c (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(reg_we_i && in_l3c && wmask_ok), .widx_i(idx_l3c), .wmask_i(wmask),
    .ridx_i(idx_l3c), .rmask_o(r_l3c), .rhit_o(h_l3c),
    .lidx_i(req_cos), .lmask_o(k_l3c)
  );

  logic [MASK_W-1:0] rd_mask;
  always_comb begin
    rd_mask = '0;
    if (hit_l2)       rd_mask = r_l2;
    else if (hit_l3d) rd_mask = r_l3d;
    else if (hit_l3c) rd_mask = r_l3c;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_rdata_o <= '0;
      reg_err_o   <= 1'b0;
    end else begin
      reg_err_o <= (reg_we_i && !(hit_any && wmask_ok)) || (reg_re_i && !hit_any);
      if (reg_re_i) reg_rdata_o <= {{(DATA_W-MASK_W){1'b0}}, rd_mask};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o    <= 1'b0;
      l2_mask_o      <= '1;
      l3_data_mask_o <= '1;
      l3_code_mask_o <= '1;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        l2_mask_o      <= k_l2;
        l3_data_mask_o <= k_l3d;
        l3_code_mask_o <= l3_cdp_i ? k_l3c : k_l3d;
      end
    end
  end

  l3_state_e l3_state;
  assign l3_state = l3_cdp_i ? L3_CDP : L3_ALLOC;
  assign cap_o    = {1'b1, l3_state};
endmodule

// File: rtl/cmu_chk.sv
module cmu_chk #(
  parameter int MASK_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              l3_cdp_i,
  input logic              reg_we_i,
  input logic              reg_re_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic              reg_err_o,
  input logic              req_valid_i,
  input logic              rsp_valid_o,
  input logic [MASK_W-1:0] l2_mask_o,
  input logic [MASK_W-1:0] l3_code_mask_o,
  input logic [MASK_W-1:0] l3_data_mask_o,
  input logic [2:0]        cap_o
);
  function automatic logic one_run(logic [MASK_W-1:0] m);
    logic [MASK_W-1:0] s;
    s = m + (m & (~m + MASK_W'(1)));
    return (m != '0) && ((s & m) == '0);
  endfunction

  AST_RSP_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o == $past(req_valid_i)); // R6

  AST_ERR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_err_o |-> $past(reg_we_i || reg_re_i)); // R3

  AST_BAD_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_err_o && $past(reg_re_i)) |-> (reg_rdata_o == '0)); // R4

  AST_RDATA_HI_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[DATA_W-1:MASK_W] == '0); // R5

  AST_MASKS_ONE_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (one_run(l2_mask_o) && one_run(l3_data_mask_o) && one_run(l3_code_mask_o))); // R3

  AST_UNIFIED_L3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !$past(l3_cdp_i)) |-> (l3_code_mask_o == l3_data_mask_o)); // R8

  AST_CAP_FORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_o[2] && ($countones(cap_o[1:0]) == 1)); // R9
endmodule

bind cos_mask_unit cmu_chk #(.MASK_W(MASK_W), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .l3_cdp_i(l3_cdp_i),
  .reg_we_i(reg_we_i), .reg_re_i(reg_re_i),
  .reg_rdata_o(reg_rdata_o), .reg_err_o(reg_err_o),
  .req_valid_i(req_valid_i), .rsp_valid_o(rsp_valid_o),
  .l2_mask_o(l2_mask_o), .l3_code_mask_o(l3_code_mask_o),
  .l3_data_mask_o(l3_data_mask_o), .cap_o(cap_o)
);

// File: tb/sim_cos_mask_unit.sv
module sim_cos_mask_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cdp = 1'b0;
  logic        we = 1'b0, re = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        err;
  logic        awe = 1'b0;
  logic [0:0]  atid = '0;
  logic [5:0]  acos = '0;
  logic        rv = 1'b0;
  logic [0:0]  rtid = '0;
  logic        rsp_v;
  logic [7:0]  m_l2, m_code, m_data;
  logic [2:0]  cap;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cos_mask_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .l3_cdp_i(cdp),
    .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .reg_err_o(err),
    .assoc_we_i(awe), .assoc_tid_i(atid), .assoc_cos_i(acos),
    .req_valid_i(rv), .req_tid_i(rtid),
    .rsp_valid_o(rsp_v), .l2_mask_o(m_l2), .l3_code_mask_o(m_code),
    .l3_data_mask_o(m_data), .cap_o(cap)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d, output logic e);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0; e = err;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d, output logic e);
    @(negedge clk); re = 1'b1; addr = a;
    @(negedge clk); re = 1'b0; d = rdata; e = err;
  endtask

  task automatic set_cos(logic t, logic [5:0] c);
    @(negedge clk); awe = 1'b1; atid = t; acos = c;
    @(negedge clk); awe = 1'b0;
  endtask

  task automatic req(logic t, output logic [7:0] l2, output logic [7:0] cd, output logic [7:0] dt);
    @(negedge clk); rv = 1'b1; rtid = t;
    @(negedge clk); rv = 1'b0;
    l2 = m_l2; cd = m_code; dt = m_data;
  endtask

  task automatic t_reset();
    logic [7:0] a, b, c;
    chk("R9 cap alloc-only", 32'(cap), 32'h5);
    req(1'b0, a, b, c);
    chk("R1 l2 open", 32'(a), 32'hFF);
    chk("R1 code open", 32'(b), 32'hFF);
    chk("R1 data open", 32'(c), 32'hFF);
  endtask

  task automatic t_l2_write();
    logic e; logic [31:0] d;
    wr(12'hD11, 32'h7F, e); chk("R2 write err", 32'(e), 0);
    rd(12'hD11, d, e);      chk("R2 readback", d, 32'h7F); chk("R2 read err", 32'(e), 0);
    wr(12'hD12, 32'hABCD_FF3C, e); chk("R5 high bits err", 32'(e), 0);
    rd(12'hD12, d, e);      chk("R5 high bits dropped", d, 32'h3C);
  endtask

  task automatic t_reject();
    logic e; logic [31:0] d;
    wr(12'hD11, 32'h5A, e); chk("R3 split mask err", 32'(e), 1);
    rd(12'hD11, d, e);      chk("R3 entry kept", d, 32'h7F);
    wr(12'hD11, 32'hFF00, e); chk("R3 zero mask err", 32'(e), 1);
    rd(12'hD11, d, e);      chk("R3 entry kept after zero", d, 32'h7F);
  endtask

  task automatic t_unimpl();
    logic e; logic [31:0] d;
    rd(12'hD14, d, e); chk("R4 l2 depth data", d, 0); chk("R4 l2 depth err", 32'(e), 1);
    rd(12'h100, d, e); chk("R4 outside data", d, 0); chk("R4 outside err", 32'(e), 1);
    rd(12'hCD0, d, e); chk("R4 code off data", d, 0); chk("R4 code off err", 32'(e), 1);
    rd(12'hC98, d, e); chk("R4 l3 depth err", 32'(e), 1);
  endtask

  task automatic t_assoc();
    logic [7:0] a, b, c;
    set_cos(1'b1, 6'd1);
    req(1'b1, a, b, c); chk("R6 tid1 l2", 32'(a), 32'h7F); chk("R6 tid1 l3", 32'(c), 32'hFF);
    req(1'b0, a, b, c); chk("R6 tid0 l2", 32'(a), 32'hFF);
  endtask

  task automatic t_range();
    logic e; logic [7:0] a, b, c;
    wr(12'hC95, 32'h0F, e); chk("R8 l3 write err", 32'(e), 0);
    set_cos(1'b1, 6'd5);
    req(1'b1, a, b, c);
    chk("R7 l2 beyond depth", 32'(a), 32'hFF);
    chk("R7 l3 data enforced", 32'(c), 32'h0F);
    chk("R8 code mirrors unified", 32'(b), 32'h0F);
    set_cos(1'b1, 6'd9);
    req(1'b1, a, b, c);
    chk("R7 all open l2", 32'(a), 32'hFF);
    chk("R7 all open l3", 32'(c), 32'hFF);
  endtask

  task automatic t_cdp();
    logic e; logic [7:0] a, b, c;
    @(negedge clk); cdp = 1'b1;
    @(negedge clk); chk("R9 cap cdp", 32'(cap), 32'h6);
    wr(12'hCD5, 32'h03, e); chk("R8 code write err", 32'(e), 0);
    set_cos(1'b1, 6'd5);
    req(1'b1, a, b, c);
    chk("R8 cdp code", 32'(b), 32'h03);
    chk("R8 cdp data", 32'(c), 32'h0F);
    @(negedge clk); cdp = 1'b0;
    @(negedge clk); chk("R9 cap back", 32'(cap), 32'h5);
  endtask

  task automatic t_same_cycle();
    logic [7:0] a, b, c;
    @(negedge clk); awe = 1'b1; atid = 1'b0; acos = 6'd1; rv = 1'b1; rtid = 1'b0;
    @(negedge clk); awe = 1'b0; rv = 1'b0;
    chk("R10 assoc same cycle old", 32'(m_l2), 32'hFF);
    req(1'b0, a, b, c); chk("R10 assoc next new", 32'(a), 32'h7F);
    @(negedge clk); we = 1'b1; addr = 12'hD11; wdata = 32'h1F; rv = 1'b1; rtid = 1'b0;
    @(negedge clk); we = 1'b0; rv = 1'b0;
    chk("R10 mask same cycle old", 32'(m_l2), 32'h7F);
    req(1'b0, a, b, c); chk("R10 mask next new", 32'(a), 32'h1F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_l2_write();
    t_reject();
    t_unimpl();
    t_assoc();
    t_range();
    t_cdp();
    t_same_cycle();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule